// File: doc/BRIEF.md
# Program Counter and Link Unit

This block keeps the fetch address of a simple processor front end and decides, once per clock, where the next fetch begins. In straight-line code the address steps forward by the length of the current instruction, which is either two or four bytes. Three kinds of redirect can override that step. The first is a write from the register-file write port whose destination index is the program counter. The second is a subroutine call with an explicit target. The third is a return that copies the link register's current contents into the program counter.

Every redirect produces a one-cycle flush pulse in the cycle the new address appears on the output. A call also emits a register-file write of its return address into the fixed link register. The return address is the call's own address plus its length.

Control is a two-state machine. `ST_SEQ` is the normal state, with no flush. `ST_FLUSH` is the state entered on the clock edge that took a redirect, and `flush_o` is driven from it. There are four transitions. `SEQ->SEQ` happens on an advance or a hold. `SEQ->FLUSH` happens on a redirect. `FLUSH->FLUSH` happens on a redirect in the flush cycle. `FLUSH->SEQ` happens when no redirect is pending. Reset places the machine in `ST_SEQ` with the program counter at the reset vector.

Top module: `pc_link_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_o` equals the reset vector parameter (default 0x100) with bit 0 cleared, and both `flush_o` and `lr_we_o` are 0.
- R2: With no redirect, `adv_i`=1 adds 2 to `pc_o` on the next edge when `long_i`=0, and adds 4 when `long_i`=1. With `adv_i`=0 the PC holds.
- R3: When `rf_we_i`=1 and `rf_waddr_i` equals the PC index (default 15), the PC loads `rf_wdata_i` with bit 0 cleared. A write to any other index leaves the PC and `flush_o` unchanged.
- R4: A call (`call_i`=1) loads the PC with `call_tgt_i` with bit 0 cleared.
- R5: A return (`ret_i`=1) loads the PC with `lr_val_i` with bit 0 cleared.
- R6: Any redirect wins over a sequential advance. Among redirects the priority is PC register write first, then call, then return.
- R7: `flush_o` is 1 for exactly the cycle after each edge that took a redirect, and is 0 after every non-redirect edge.
- R8: `lr_we_o` pulses only when a call wins arbitration. At that point `lr_waddr_o` equals the link index (default 14) and `lr_wdata_o` equals the call's PC plus 2 (`long_i`=0) or 4 (`long_i`=1). The pulse appears in the same cycle as the flush.
- R9: Bit 0 of `pc_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Current instruction completes; step sequentially |
| long_i | input | 1 | Current instruction is 4 bytes (1) or 2 bytes (0) |
| call_i | input | 1 | Call request |
| call_tgt_i | input | AW | Call target address |
| ret_i | input | 1 | Return request |
| lr_val_i | input | AW | Current link register contents |
| rf_we_i | input | 1 | Register-file write strobe |
| rf_waddr_i | input | RW | Register-file write index |
| rf_wdata_i | input | AW | Register-file write data |
| pc_o | output | AW | Current program counter |
| flush_o | output | 1 | Pipeline flush pulse |
| lr_we_o | output | 1 | Link register write strobe |
| lr_waddr_o | output | RW | Link register write index |
| lr_wdata_o | output | AW | Return address to store |

## Verification
The assertions assume that every input is stable and known at the rising edge while reset is released. They do not assume that redirect requests are exclusive. Overlapping requests are legal, and the properties work out the winner from the ports. The properties also assume that the PC never wraps, because the directed stimulus keeps every address far below the top of the address space. Inputs change only at falling edges, and all requests return to zero between scenarios. This ensures each property's antecedent comes from exactly one intended cycle.

// File: rtl/pc_link_pkg.sv
`timescale 1ns/1ps
package pc_link_pkg;

    // Winning source of a non-sequential PC load, in priority order
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RFW  = 2'd1,
        SRC_CALL = 2'd2,
        SRC_RET  = 2'd3
    } redir_src_e;

    // Control states of the PC sequencer
    typedef enum logic {
        ST_SEQ   = 1'b0,
        ST_FLUSH = 1'b1
    } pc_state_e;

endpackage

// File: rtl/pc_step_add.sv
`timescale 1ns/1ps
module pc_step_add #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_i,
    input  logic          long_i,
    output logic [AW-1:0] sum_o
);
    localparam logic [AW-1:0] STEP_SHORT = AW'(2);
    localparam logic [AW-1:0] STEP_LONG  = AW'(4);

    always_comb begin
        sum_o = base_i + (long_i ? STEP_LONG : STEP_SHORT);
    end
endmodule

// File: rtl/pc_redirect_arb.sv
`timescale 1ns/1ps
module pc_redirect_arb
    import pc_link_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RW     = 4,
    parameter int PC_IDX = 15
) (
    input  logic          rf_we_i,
    input  logic [RW-1:0] rf_waddr_i,
    input  logic [AW-1:0] rf_wdata_i,
    input  logic          call_i,
    input  logic [AW-1:0] call_tgt_i,
    input  logic          ret_i,
    input  logic [AW-1:0] lr_val_i,
    output logic          redir_o,
    output redir_src_e    src_o,
    output logic [AW-1:0] tgt_o
);
    localparam logic [RW-1:0] PC_SEL  = RW'(PC_IDX);
    localparam logic [AW-1:0] LSB_CLR = ~AW'(1);

    logic          pc_hit;
    logic [AW-1:0] raw_tgt;

    assign pc_hit = rf_we_i && (rf_waddr_i == PC_SEL);

    always_comb begin
        src_o   = SRC_NONE;
        raw_tgt = '0;
        if (pc_hit) begin
            src_o   = SRC_RFW;
            raw_tgt = rf_wdata_i;
        end else if (call_i) begin
            src_o   = SRC_CALL;
            raw_tgt = call_tgt_i;
        end else if (ret_i) begin
            src_o   = SRC_RET;
            raw_tgt = lr_val_i;
        end
    end

    assign redir_o = (src_o != SRC_NONE);
    assign tgt_o   = raw_tgt & LSB_CLR;
endmodule

// File: rtl/pc_link_unit.sv
`timescale 1ns/1ps
module pc_link_unit
    import pc_link_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          RW        = 4,
    parameter int          PC_IDX    = 15,
    parameter int          LR_IDX    = 14,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          long_i,
    input  logic          call_i,
    input  logic [AW-1:0] call_tgt_i,
    input  logic          ret_i,
    input  logic [AW-1:0] lr_val_i,
    input  logic          rf_we_i,
    input  logic [RW-1:0] rf_waddr_i,
    input  logic [AW-1:0] rf_wdata_i,
    output logic [AW-1:0] pc_o,
    output logic          flush_o,
    output logic          lr_we_o,
    output logic [RW-1:0] lr_waddr_o,
    output logic [AW-1:0] lr_wdata_o
);
    localparam logic [AW-1:0] RESET_PC = AW'(RESET_VEC) & ~AW'(1);
    localparam logic [RW-1:0] LR_SEL   = RW'(LR_IDX);

    pc_state_e     state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [AW-1:0] step_sum;
    logic          redir;
    redir_src_e    src;
    logic [AW-1:0] tgt;
    logic          lr_we_q;
    logic [AW-1:0] lr_data_q;

    pc_step_add #(.AW(AW)) u_step (
        .base_i (pc_q),
        .long_i (long_i),
        .sum_o  (step_sum)
    );

    pc_redirect_arb #(.AW(AW), .RW(RW), .PC_IDX(PC_IDX)) u_arb (
        .rf_we_i    (rf_we_i),
        .rf_waddr_i (rf_waddr_i),
        .rf_wdata_i (rf_wdata_i),
        .call_i     (call_i),
        .call_tgt_i (call_tgt_i),
        .ret_i      (ret_i),
        .lr_val_i   (lr_val_i),
        .redir_o    (redir),
        .src_o      (src),
        .tgt_o      (tgt)
    );

    // Next-state and next-PC selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:   state_d = redir ? ST_FLUSH : ST_SEQ;
            ST_FLUSH: state_d = redir ? ST_FLUSH : ST_SEQ;
            default:  state_d = ST_SEQ;
        endcase
        if (redir) begin
            pc_d = tgt;
        end else if (adv_i) begin
            pc_d = step_sum;
        end else begin
            pc_d = pc_q;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            pc_q    <= RESET_PC;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Link-write registers, aligned with the flush cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_we_q   <= 1'b0;
            lr_data_q <= '0;
        end else begin
            lr_we_q <= (src == SRC_CALL);
            if (src == SRC_CALL) begin
                lr_data_q <= step_sum;
            end
        end
    end

    // Outputs
    always_comb begin
        pc_o       = pc_q;
        flush_o    = (state_q == ST_FLUSH);
        lr_we_o    = lr_we_q;
        lr_waddr_o = LR_SEL;
        lr_wdata_o = lr_data_q;
    end
endmodule

// File: rtl/pc_link_unit_chk.sv
`timescale 1ns/1ps
module pc_link_unit_chk #(
    parameter int AW     = 32,
    parameter int RW     = 4,
    parameter int PC_IDX = 15,
    parameter int LR_IDX = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv_i,
    input logic          long_i,
    input logic          call_i,
    input logic [AW-1:0] call_tgt_i,
    input logic          ret_i,
    input logic [AW-1:0] lr_val_i,
    input logic          rf_we_i,
    input logic [RW-1:0] rf_waddr_i,
    input logic [AW-1:0] rf_wdata_i,
    input logic [AW-1:0] pc_o,
    input logic          flush_o,
    input logic          lr_we_o,
    input logic [RW-1:0] lr_waddr_o,
    input logic [AW-1:0] lr_wdata_o
);
    logic          armed;
    logic          wr_pc, any_redir, call_wins, ret_wins;
    logic [AW-1:0] step, call_clr, ret_clr, wr_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign wr_pc     = rf_we_i && (rf_waddr_i == RW'(PC_IDX));
    assign any_redir = wr_pc || call_i || ret_i;
    assign call_wins = call_i && !wr_pc;
    assign ret_wins  = ret_i && !call_i && !wr_pc;
    assign step      = long_i ? AW'(4) : AW'(2);
    assign call_clr  = call_tgt_i & ~AW'(1);
    assign ret_clr   = lr_val_i & ~AW'(1);
    assign wr_clr    = rf_wdata_i & ~AW'(1);

    p_lsb_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == 1'b0);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !any_redir && adv_i |=> pc_o == $past(pc_o) + $past(step));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !any_redir && !adv_i |=> $stable(pc_o));

    p_rf_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && wr_pc |=> pc_o == $past(wr_clr));

    p_call_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && call_wins |=> pc_o == $past(call_clr));

    p_ret_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ret_wins |=> pc_o == $past(ret_clr));

    p_flush_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> flush_o == $past(any_redir));

    p_link_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> lr_we_o == $past(call_wins));

    p_link_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && call_wins |=> lr_wdata_o == $past(pc_o) + $past(step));

    p_link_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> (lr_waddr_o == RW'(LR_IDX)) && flush_o);
endmodule

bind pc_link_unit pc_link_unit_chk #(
    .AW(AW), .RW(RW), .PC_IDX(PC_IDX), .LR_IDX(LR_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .long_i(long_i),
    .call_i(call_i), .call_tgt_i(call_tgt_i), .ret_i(ret_i),
    .lr_val_i(lr_val_i), .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i),
    .rf_wdata_i(rf_wdata_i), .pc_o(pc_o), .flush_o(flush_o),
    .lr_we_o(lr_we_o), .lr_waddr_o(lr_waddr_o), .lr_wdata_o(lr_wdata_o)
);

// File: tb/pc_link_unit_test.sv
`timescale 1ns/1ps
module pc_link_unit_test;
    localparam int AW = 32;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          adv_i, long_i, call_i, ret_i, rf_we_i;
    logic [AW-1:0] call_tgt_i, lr_val_i, rf_wdata_i;
    logic [RW-1:0] rf_waddr_i;
    logic [AW-1:0] pc_o, lr_wdata_o;
    logic          flush_o, lr_we_o;
    logic [RW-1:0] lr_waddr_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pc_link_unit uut (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .long_i(long_i),
        .call_i(call_i), .call_tgt_i(call_tgt_i), .ret_i(ret_i),
        .lr_val_i(lr_val_i), .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i),
        .rf_wdata_i(rf_wdata_i), .pc_o(pc_o), .flush_o(flush_o),
        .lr_we_o(lr_we_o), .lr_waddr_o(lr_waddr_o), .lr_wdata_o(lr_wdata_o)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        adv_i = 0; long_i = 0; call_i = 0; ret_i = 0; rf_we_i = 0;
        call_tgt_i = '0; lr_val_i = '0; rf_wdata_i = '0; rf_waddr_i = '0;
    endtask

    // One clock: inputs set at falling edge, outputs sampled at next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        tick(); tick();
        check("R1 pc in reset", pc_o, 32'h100);
        check("R1 flush in reset", AW'(flush_o), 0);
        check("R1 lr_we in reset", AW'(lr_we_o), 0);
        rst_n = 1;
        tick();
        check("R1 pc after reset", pc_o, 32'h100);
        check("R1 flush after reset", AW'(flush_o), 0);
    endtask

    task automatic t_sequential();
        adv_i = 1; long_i = 0; tick();
        check("R2 step by 2", pc_o, 32'h102);
        check("R7 no flush on step", AW'(flush_o), 0);
        long_i = 1; tick();
        check("R2 step by 4", pc_o, 32'h106);
        adv_i = 0; tick();
        check("R2 hold", pc_o, 32'h106);
        check("R9 lsb zero", AW'(pc_o[0]), 0);
        idle_inputs();
    endtask

    task automatic t_rf_write();
        rf_we_i = 1; rf_waddr_i = 4'd3; rf_wdata_i = 32'h9999; tick();
        check("R3 other index pc", pc_o, 32'h106);
        check("R3 other index flush", AW'(flush_o), 0);
        rf_waddr_i = 4'd15; rf_wdata_i = 32'h2001; adv_i = 1; tick();
        check("R3 pc write lsb cleared", pc_o, 32'h2000);
        check("R6 redirect beats advance", AW'(flush_o), 1);
        check("R8 no link on rf write", AW'(lr_we_o), 0);
        idle_inputs(); tick();
        check("R7 flush one cycle", AW'(flush_o), 0);
        check("R7 pc kept", pc_o, 32'h2000);
    endtask

    task automatic t_call();
        call_i = 1; call_tgt_i = 32'h3000; long_i = 1; tick();
        check("R4 call target", pc_o, 32'h3000);
        check("R7 flush on call", AW'(flush_o), 1);
        check("R8 link strobe", AW'(lr_we_o), 1);
        check("R8 link index", AW'(lr_waddr_o), 14);
        check("R8 link data long", lr_wdata_o, 32'h2004);
        call_tgt_i = 32'h4003; long_i = 0; tick();
        check("R4 call target lsb", pc_o, 32'h4002);
        check("R7 back-to-back flush", AW'(flush_o), 1);
        check("R8 link data short", lr_wdata_o, 32'h3002);
        idle_inputs(); tick();
        check("R8 link strobe drops", AW'(lr_we_o), 0);
    endtask

    task automatic t_return();
        ret_i = 1; lr_val_i = 32'h2005; tick();
        check("R5 return target", pc_o, 32'h2004);
        check("R5 flush on return", AW'(flush_o), 1);
        check("R8 no link on return", AW'(lr_we_o), 0);
        idle_inputs(); tick();
    endtask

    task automatic t_priority();
        rf_we_i = 1; rf_waddr_i = 4'd15; rf_wdata_i = 32'h5000;
        call_i = 1; call_tgt_i = 32'h6000; ret_i = 1; lr_val_i = 32'h7700; tick();
        check("R6 rf write wins", pc_o, 32'h5000);
        check("R8 losing call no link", AW'(lr_we_o), 0);
        rf_we_i = 0; call_tgt_i = 32'h7000; long_i = 0; tick();
        check("R6 call beats return", pc_o, 32'h7000);
        check("R8 link data", lr_wdata_o, 32'h5002);
        idle_inputs(); tick();
        check("R7 flush clears", AW'(flush_o), 0);
        check("R9 lsb zero end", AW'(pc_o[0]), 0);
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_rf_write();
        t_call();
        t_return();
        t_priority();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule